// File: doc/BRIEF.md
# Two-wire bus recovery sequencer

This block sits on the controller side of a two-wire serial memory bus and returns the bus to a clean idle state after a transfer was cut short, after a power loss, or after a system reset. When it sees a single-cycle request, it steps the two open-drain lines through a fixed recovery pattern. The pattern is a start condition, then nine dummy clock pulses with the data line released, then a second start condition, then a stop condition. When the pattern is complete, it raises a one-cycle done pulse and leaves both lines released.

During the dummy clocks the data line is left released. A target that was stopped partway through a byte it was sending can therefore clock out the rest of that byte and let go of the line. Every SCL high and low phase lasts a programmable number of system clocks. The phase length is sampled when the request is accepted. With a 50 MHz system clock, a phase length of 250 gives a bit rate of about 100 kHz. Ordinary byte transfers, addressing and clock stretching are not part of this block.

Top module: `twr_recover`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both drive-low enables, `busy_o` and `done_o` are 0.
- R2: After a request, one phase follows with both lines released. Then SDA is driven low while SCL stays released, which is the first start condition. Then SCL is driven low while SDA is still held low.
- R3: After the first start, SCL gives exactly nine complete high pulses with SDA released. Each pulse is preceded by a low phase. Then one more low phase follows with SDA released. Phase pairs are encoded as {scl_low_o, sda_low_o}: low phase = 2'b10, high phase = 2'b00.
- R4: SDA changes while SCL is released only to form a start (SDA going low) or a stop (SDA going high). Across one recovery there are exactly three such changes. SCL and SDA never change on the same cycle.
- R5: After the last low phase, SCL is released with SDA released. Then SDA is driven low (second start), and then SDA is released with SCL still released (stop). The phase patterns are 2'b00, 2'b01, 2'b00.
- R6: Each of the 25 phases lasts P system clocks. P is the value of `phase_len_i` at the request, and a value of 0 is taken as 1. So `busy_o` stays high for exactly 25·P cycles.
- R7: `busy_o` rises on the cycle after the request is accepted and stays high until the stop phase ends. `done_o` is high for exactly the one cycle that follows.
- R8: A request that arrives while `busy_o` is high has no effect, and neither does a change of `phase_len_i` while busy. The pattern and its length are unchanged, and only one done pulse is produced.
- R9: A synchronous reset in the middle of a recovery releases both lines and clears `busy_o` on the next cycle. A later request then runs a complete recovery.
- R10: Whenever `busy_o` is low, including the done cycle, both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Single-cycle recovery request |
| phase_len_i | input | LEN_W | System clocks per SCL phase (0 is taken as 1) |
| scl_low_o | output | 1 | 1 = pull SCL low, 0 = release |
| sda_low_o | output | 1 | 1 = pull SDA low, 0 = release |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle pulse when the recovery has finished |

## Verification
The hardest situation to reach from the ports is a second request, carrying a different phase length, that lands in the middle of a recovery. It has to be shown that this request neither restarts the pattern nor stretches the phases. The stimulus injects such a request partway through a run with P = 2 and then checks every later cycle against the original schedule. A synchronous reset asserted during the dummy clocks is a second hard case. It is followed by a fresh request to show that no state from the aborted run carries over.

// File: rtl/twr_pkg.sv
package twr_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETUP,
      ST_START,
      ST_GRAB,
      ST_LOW,
      ST_HIGH,
      ST_TAIL,
      ST_RSETUP,
      ST_RSTART,
      ST_STOP,
      ST_DONE
   } twr_state_e;

   typedef struct packed {
      logic scl_low;
      logic sda_low;
   } twr_lines_t;

   localparam twr_lines_t LINES_REL   = '{scl_low: 1'b0, sda_low: 1'b0};
   localparam twr_lines_t LINES_SDA   = '{scl_low: 1'b0, sda_low: 1'b1};
   localparam twr_lines_t LINES_SCL   = '{scl_low: 1'b1, sda_low: 1'b0};
   localparam twr_lines_t LINES_BOTH  = '{scl_low: 1'b1, sda_low: 1'b1};

   function automatic twr_lines_t twr_decode(input twr_state_e st);
      twr_lines_t l;
      case (st)
         ST_START, ST_RSTART: l = LINES_SDA;
         ST_GRAB:             l = LINES_BOTH;
         ST_LOW, ST_TAIL:     l = LINES_SCL;
         default:             l = LINES_REL;
      endcase
      return l;
   endfunction

endpackage

// File: rtl/twr_timer.sv
module twr_timer #(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             reload_i,
   output logic             expire_o
);
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] eff_len;

   assign eff_len  = (len_i == '0) ? LEN_W'(1) : len_i;
   assign expire_o = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         len_q <= LEN_W'(1);
         cnt_q <= '0;
      end else if (load_i) begin
         len_q <= eff_len;
         cnt_q <= eff_len - LEN_W'(1);
      end else if (reload_i) begin
         cnt_q <= len_q - LEN_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - LEN_W'(1);
      end
   end
endmodule

// File: rtl/twr_seq.sv
module twr_seq
   import twr_pkg::*;
#(
   parameter int DUMMY_CLOCKS = 9
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       req_i,
   input  logic       expire_i,
   output logic       accept_o,
   output logic       reload_o,
   output twr_state_e state_d_o,
   output logic       busy_o,
   output logic       done_o
);
   localparam int PW = (DUMMY_CLOCKS > 1) ? $clog2(DUMMY_CLOCKS) : 1;
   localparam logic [PW-1:0] LAST_PULSE = PW'(DUMMY_CLOCKS - 1);

   twr_state_e    state_q, state_d;
   logic [PW-1:0] pulse_q, pulse_d;
   logic          idle_like;

   assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
   assign accept_o  = idle_like && req_i;

   always_comb begin
      state_d  = state_q;
      pulse_d  = pulse_q;
      reload_o = 1'b0;
      if (idle_like) begin
         if (req_i) begin
            state_d = ST_SETUP;
            pulse_d = '0;
         end else begin
            state_d = ST_IDLE;
         end
      end else if (expire_i) begin
         reload_o = 1'b1;
         case (state_q)
            ST_SETUP:  state_d = ST_START;
            ST_START:  state_d = ST_GRAB;
            ST_GRAB:   state_d = ST_LOW;
            ST_LOW:    state_d = ST_HIGH;
            ST_HIGH: begin
               if (pulse_q == LAST_PULSE) begin
                  state_d = ST_TAIL;
               end else begin
                  pulse_d = pulse_q + PW'(1);
                  state_d = ST_LOW;
               end
            end
            ST_TAIL:   state_d = ST_RSETUP;
            ST_RSETUP: state_d = ST_RSTART;
            ST_RSTART: state_d = ST_STOP;
            ST_STOP:   state_d = ST_DONE;
            default:   state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         pulse_q <= '0;
      end else begin
         state_q <= state_d;
         pulse_q <= pulse_d;
      end
   end

   assign state_d_o = rst ? ST_IDLE : state_d;
   assign busy_o    = !idle_like;
   assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/twr_linedrv.sv
module twr_linedrv
   import twr_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  twr_state_e state_d_i,
   output logic       scl_low_o,
   output logic       sda_low_o
);
   twr_lines_t next_lines, lines_q;

   assign next_lines = twr_decode(state_d_i);

   always_ff @(posedge clk) begin
      if (rst) lines_q <= LINES_REL;
      else     lines_q <= next_lines;
   end

   assign scl_low_o = lines_q.scl_low;
   assign sda_low_o = lines_q.sda_low;
endmodule

// File: rtl/twr_recover.sv
module twr_recover
   import twr_pkg::*;
#(
   parameter int LEN_W        = 12,
   parameter int DUMMY_CLOCKS = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_i,
   input  logic [LEN_W-1:0] phase_len_i,
   output logic             scl_low_o,
   output logic             sda_low_o,
   output logic             busy_o,
   output logic             done_o
);
   generate
      if (LEN_W < 1 || LEN_W > 24) begin : g_bad_len
         $error("twr_recover: LEN_W must lie in 1..24");
      end
      if (DUMMY_CLOCKS < 1 || DUMMY_CLOCKS > 64) begin : g_bad_dummy
         $error("twr_recover: DUMMY_CLOCKS must lie in 1..64");
      end
   endgenerate

   logic       accept, reload, expire;
   twr_state_e state_d;

   twr_timer #(.LEN_W(LEN_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load_i   (accept),
      .len_i    (phase_len_i),
      .reload_i (reload),
      .expire_o (expire)
   );

   twr_seq #(.DUMMY_CLOCKS(DUMMY_CLOCKS)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .req_i     (req_i),
      .expire_i  (expire),
      .accept_o  (accept),
      .reload_o  (reload),
      .state_d_o (state_d),
      .busy_o    (busy_o),
      .done_o    (done_o)
   );

   twr_linedrv u_lines (
      .clk       (clk),
      .rst       (rst),
      .state_d_i (state_d),
      .scl_low_o (scl_low_o),
      .sda_low_o (sda_low_o)
   );
endmodule

// File: rtl/twr_recover_chk.sv
module twr_recover_chk #(
   parameter int DUMMY_CLOCKS = 9
) (
   input logic clk,
   input logic rst,
   input logic req_i,
   input logic scl_low_o,
   input logic sda_low_o,
   input logic busy_o,
   input logic done_o
);
   logic       scl_prev, sda_prev;
   logic [7:0] rise_cnt, start_cnt, stop_cnt;

   always_ff @(posedge clk) begin
      scl_prev <= scl_low_o;
      sda_prev <= sda_low_o;
      if (rst || (!busy_o && !done_o)) begin
         rise_cnt  <= '0;
         start_cnt <= '0;
         stop_cnt  <= '0;
      end else begin
         if (scl_prev && !scl_low_o) rise_cnt <= rise_cnt + 8'd1;
         if (!scl_prev && !scl_low_o && !sda_prev && sda_low_o) start_cnt <= start_cnt + 8'd1;
         if (!scl_prev && !scl_low_o && sda_prev && !sda_low_o) stop_cnt <= stop_cnt + 8'd1;
      end
   end

   // R1 / R9
   a_r9_reset_releases: assert property (@(posedge clk)
      rst |=> (!scl_low_o && !sda_low_o && !busy_o && !done_o));

   a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
      !busy_o |-> (!scl_low_o && !sda_low_o));

   a_r7_busy_after_req: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_o) |-> $past(req_i));

   a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
      done_o |-> ($past(busy_o) && !busy_o));

   a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   a_r4_no_joint_change: assert property (@(posedge clk) disable iff (rst)
      !(!$stable(scl_low_o) && !$stable(sda_low_o)));

   a_r3_clock_count: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (rise_cnt == 8'(DUMMY_CLOCKS + 1)));

   a_r5_start_stop_count: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (start_cnt == 8'd2 && stop_cnt == 8'd1));
endmodule

bind twr_recover twr_recover_chk #(.DUMMY_CLOCKS(DUMMY_CLOCKS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_i     (req_i),
   .scl_low_o (scl_low_o),
   .sda_low_o (sda_low_o),
   .busy_o    (busy_o),
   .done_o    (done_o)
);

// File: tb/twr_recover_bench.sv
module twr_recover_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LEN_W      = 12;
   localparam int NPHASE     = 25;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             req = 1'b0;
   logic [LEN_W-1:0] plen = '0;
   logic             scl_low, sda_low, busy, done;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   twr_recover #(.LEN_W(LEN_W), .DUMMY_CLOCKS(9)) u_twr_recover (
      .clk         (clk),
      .rst         (rst),
      .req_i       (req),
      .phase_len_i (plen),
      .scl_low_o   (scl_low),
      .sda_low_o   (sda_low),
      .busy_o      (busy),
      .done_o      (done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // expected {scl_low,sda_low} for phase index, from R2/R3/R5
   function automatic logic [1:0] exp_lines(input int ph);
      if (ph == 0) return 2'b00;
      if (ph == 1) return 2'b01;
      if (ph == 2) return 2'b11;
      if (ph <= 20) return ((ph - 3) % 2 == 0) ? 2'b10 : 2'b00;
      if (ph == 21) return 2'b10;
      if (ph == 22) return 2'b00;
      if (ph == 23) return 2'b01;
      return 2'b00;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk({scl_low, sda_low, busy, done} == 4'b0, "R1 in reset", {scl_low, sda_low, busy, done}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk({scl_low, sda_low, busy, done} == 4'b0, "R1 after reset", {scl_low, sda_low, busy, done}, 0);
   endtask

   // full recovery; inject>=0 sends a second request (new length) at that cycle
   task automatic run_seq(input int p_in, input int p_eff, input int inject, input string tag);
      logic [1:0] prev, cur;
      int starts = 0, stops = 0, rises = 0, sda_hi_chg = 0, joint = 0;
      req = 1'b1; plen = LEN_W'(p_in);
      @(negedge clk);
      req = 1'b0;
      prev = 2'b00;
      for (int j = 0; j < NPHASE * p_eff; j++) begin
         int ph = j / p_eff;
         string t;
         cur = {scl_low, sda_low};
         if (ph <= 2) t = "R2";
         else if (ph <= 21) t = "R3";
         else t = "R5";
         chk(cur == exp_lines(ph), $sformatf("%s %s lines j=%0d", tag, t, j), cur, exp_lines(ph));
         chk(busy && !done, $sformatf("%s R7/R6 busy j=%0d", tag, j), {busy, done}, 2);
         if (prev[1] && !cur[1]) rises++;
         if (!prev[1] && !cur[1] && prev[0] != cur[0]) begin
            sda_hi_chg++;
            if (cur[0]) starts++; else stops++;
         end
         if (prev[1] != cur[1] && prev[0] != cur[0]) joint++;
         prev = cur;
         if (j == inject) begin req = 1'b1; plen = LEN_W'(7); end
         else req = 1'b0;
         @(negedge clk);
      end
      req = 1'b0;
      chk(done && !busy, {tag, " R7 done after stop / R6 length"}, {busy, done}, 1);
      chk({scl_low, sda_low} == 2'b00, {tag, " R10 released at done"}, {scl_low, sda_low}, 0);
      chk(rises == 10, {tag, " R3 scl rises"}, rises, 10);
      chk(starts == 2 && stops == 1, {tag, " R5 starts/stops"}, starts * 10 + stops, 21);
      chk(sda_hi_chg == 3, {tag, " R4 sda changes with scl high"}, sda_hi_chg, 3);
      chk(joint == 0, {tag, " R4 joint changes"}, joint, 0);
      @(negedge clk);
      chk(!done && !busy, {tag, " R7 done single cycle"}, {busy, done}, 0);
      repeat (3) begin
         chk({scl_low, sda_low} == 2'b00, {tag, " R10 idle released"}, {scl_low, sda_low}, 0);
         @(negedge clk);
      end
   endtask

   task automatic t_midreset();
      req = 1'b1; plen = LEN_W'(2);
      @(negedge clk);
      req = 1'b0;
      repeat (15) @(negedge clk);
      chk(busy, "R9 busy before reset", busy, 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk({scl_low, sda_low, busy, done} == 4'b0, "R9 reset mid-run", {scl_low, sda_low, busy, done}, 0);
      repeat (4) begin
         @(negedge clk);
         chk({scl_low, sda_low, busy} == 3'b0, "R9 stays idle", {scl_low, sda_low, busy}, 0);
      end
   endtask

   initial begin
      t_reset();
      run_seq(1, 1, -1, "P1");
      run_seq(3, 3, -1, "R6 P3");
      run_seq(0, 1, -1, "R6 P0");
      run_seq(2, 2, 11, "R8 inject");
      t_midreset();
      run_seq(2, 2, -1, "R9 after reset");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule